// File: doc/BRIEF.md
# Peripheral Resource Routing Decoder

This block takes a parallel snapshot of the peripheral configuration registers and works out what each on-chip function is given. The functions are the floppy controller, the primary and secondary disk address ranges, two serial ports and the parallel port. For each one it produces an enable and a base address. It also produces interrupt line numbers, DMA channel numbers, the baud clock source for each serial port, and the protocol flags and FIFO threshold for the parallel port. The register file and the peripherals themselves sit outside this block.

Every base address is a register byte shifted left by two and then masked to the alignment its function needs. Interrupt and DMA numbers are not used as raw values: they pass through fixed lookup tables. The parallel-port mode field decides which protocol flags are raised, how the base address is aligned, and whether the port is switched on at all.

All outputs are registered. Every output is loaded from the snapshot on a clock edge where the update strobe is high, and holds its value on every other edge. The owning logic pulses the strobe whenever a configuration register changes.

Top module: `periph_route_dec`

## Requirements
- R1: All outputs change only on a rising edge where `cfg_upd` is high. On that edge they take values decoded from the inputs present at that edge. While `cfg_upd` is low, they hold.
- R2: When `rst` is high at a clock edge, the outputs go to their reset values. Reset values: every enable and every parallel flag is 0, every base is 0, every IRQ number is 4'hF with its valid bit at 0, every DMA channel is 4, every baud select is 0, and the FIFO threshold is 0.
- R3: In `cfg_enables`, bit 5 enables the disk ranges, bit 4 enables the floppy controller, bit 2 enables serial port 0 and bit 3 enables serial port 1.
- R4: The floppy base is ({`cfg_fdc_base`,2'b00}) & 16'hFFF0. The primary disk base is ({`cfg_ide_pri`,2'b00}) & 16'hFFF0. The secondary disk base is ({`cfg_ide_sec`,2'b00}) & 16'hFFF0, ORed with 16'h0006.
- R5: The base of serial port n is ({byte n,2'b00}) & 16'hFFF8. Byte 0 is `cfg_ser0_base` and byte 1 is `cfg_ser1_base`. Serial base n appears at `ser_base[16n+15:16n]`.
- R6: IRQ codes map to line numbers as follows: 1→5, 2→2, 3→3, 4→4, 5→7, 6→6 and 8→10. Each of these has its valid bit at 1. Codes 0, 7 and 9–15 give 4'hF with the valid bit at 0. The floppy code is `cfg_irq_fp[7:4]` and the parallel code is `cfg_irq_fp[3:0]`. Serial port 0 takes its code from `cfg_irq_ser[7:4]` and serial port 1 from `cfg_irq_ser[3:0]`. Serial IRQ n appears at `ser_irq[4n+3:4n]`.
- R7: DMA codes map to channels as follows: code 0 gives channel 4 (none), and codes 1, 2 and 3 give channels 1, 2 and 3. The floppy code is `cfg_dma_sel[5:4]` and the parallel code is `cfg_dma_sel[1:0]`.
- R8: `ser_baud_sel[2n+1:2n]` selects the baud clock for serial port n. It is 2 (24 MHz / 3) when `cfg_clk_fast[6+n]` is 1. Otherwise it is 1 (24 MHz / 12) when `cfg_clk_mid[n]` is 1. Otherwise it is 0 (24 MHz / 13).
- R9: The parallel mode is `cfg_enables[1:0]`. Mode 0 raises only `par_ext`. Mode 1 raises `par_ecp`, and also `par_epp` when `cfg_par_opt[5]` is 1. Mode 2 raises `par_epp`, and also `par_ecp` when `cfg_par_opt[5]` is 1. Mode 3 raises no flag.
- R10: The parallel base is ({`cfg_par_base`,2'b00}) & 16'hFFFC in modes 0, 1 and 3, and & 16'hFFF8 in mode 2. `par_en` is 1 only when the mode is not 3 and the base lies from 16'h0100 up to 16'h0FFC, with that upper limit masked the same way.
- R11: `par_fifo_thr` equals `cfg_par_fifo[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_upd | input | 1 | Load strobe for the snapshot |
| cfg_enables | input | 8 | Enable bits and parallel mode |
| cfg_fdc_base | input | 8 | Floppy base byte |
| cfg_ide_pri | input | 8 | Primary disk base byte |
| cfg_ide_sec | input | 8 | Secondary disk base byte |
| cfg_par_base | input | 8 | Parallel base byte |
| cfg_ser0_base | input | 8 | Serial 0 base byte |
| cfg_ser1_base | input | 8 | Serial 1 base byte |
| cfg_dma_sel | input | 8 | DMA codes (floppy, parallel) |
| cfg_irq_fp | input | 8 | IRQ codes (floppy, parallel) |
| cfg_irq_ser | input | 8 | IRQ codes (serial 0, serial 1) |
| cfg_clk_fast | input | 8 | Fast baud clock bits |
| cfg_clk_mid | input | 8 | Medium baud clock bits |
| cfg_par_opt | input | 8 | Parallel protocol option |
| cfg_par_fifo | input | 8 | Parallel FIFO threshold |
| fdc_en | output | 1 | Floppy enable |
| fdc_base | output | 16 | Floppy base address |
| fdc_irq | output | 4 | Floppy IRQ line |
| fdc_irq_vld | output | 1 | Floppy IRQ valid |
| fdc_dma | output | 3 | Floppy DMA channel |
| ide_en | output | 1 | Disk range enable |
| ide_pri_base | output | 16 | Primary disk base |
| ide_sec_base | output | 16 | Secondary disk base |
| ser_en | output | 2 | Serial enables |
| ser_base | output | 32 | Serial bases, packed |
| ser_irq | output | 8 | Serial IRQ lines, packed |
| ser_irq_vld | output | 2 | Serial IRQ valid bits |
| ser_baud_sel | output | 4 | Baud clock selects, packed |
| par_en | output | 1 | Parallel enable |
| par_base | output | 16 | Parallel base address |
| par_irq | output | 4 | Parallel IRQ line |
| par_irq_vld | output | 1 | Parallel IRQ valid |
| par_dma | output | 3 | Parallel DMA channel |
| par_ext | output | 1 | Standard extended mode flag |
| par_ecp | output | 1 | ECP flag |
| par_epp | output | 1 | EPP flag |
| par_fifo_thr | output | 4 | Parallel FIFO threshold |

## Verification
The assertions assume three things. First, `rst` is held high for at least one edge before use. Second, `cfg_upd` is never unknown. Third, the snapshot inputs carry known values on every edge where the strobe is high, because the hold and enable-tracking properties compare outputs with the inputs seen at the strobe edge. The stimulus changes inputs and the strobe only on falling edges and raises the strobe for a single cycle at a time. Between strobes it also scrambles the snapshot, so the hold property is exercised against inputs that really do differ.

// File: rtl/route_pkg.sv
package route_pkg;

  localparam int IRQ_W   = 4;
  localparam int DMA_W   = 3;
  localparam int NUM_SER = 2;

  localparam logic [IRQ_W-1:0] IRQ_NONE = 4'hF;
  localparam logic [DMA_W-1:0] DMA_NONE = 3'd4;

  typedef enum logic [1:0] {
    BAUD_DIV13 = 2'd0,
    BAUD_DIV12 = 2'd1,
    BAUD_DIV3  = 2'd2
  } baud_sel_e;

  typedef enum logic [1:0] {
    PAR_STD = 2'd0,
    PAR_ECP = 2'd1,
    PAR_EPP = 2'd2,
    PAR_OFF = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic             vld;
    logic [IRQ_W-1:0] num;
  } irq_res_t;

  // Two-bit DMA code to channel; code zero means no channel (4).
  function automatic logic [DMA_W-1:0] dma_decode(input logic [1:0] code);
    return (code == 2'd0) ? DMA_NONE : {1'b0, code};
  endfunction

endpackage

// File: rtl/route_irq_lut.sv
module route_irq_lut
  import route_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code_i,
  output irq_res_t          res_o
);

  // Non-linear code table; unlisted codes resolve to "none".
  always_comb begin
    res_o = '{vld: 1'b0, num: IRQ_NONE};
    case (code_i)
      CODE_W'(1): res_o = '{vld: 1'b1, num: 4'd5};
      CODE_W'(2): res_o = '{vld: 1'b1, num: 4'd2};
      CODE_W'(3): res_o = '{vld: 1'b1, num: 4'd3};
      CODE_W'(4): res_o = '{vld: 1'b1, num: 4'd4};
      CODE_W'(5): res_o = '{vld: 1'b1, num: 4'd7};
      CODE_W'(6): res_o = '{vld: 1'b1, num: 4'd6};
      CODE_W'(8): res_o = '{vld: 1'b1, num: 4'd10};
      default:    res_o = '{vld: 1'b0, num: IRQ_NONE};
    endcase
  end

endmodule

// File: rtl/route_base_calc.sv
module route_base_calc #(
  parameter int          REG_W      = 8,
  parameter int          ADDR_W     = 16,
  parameter int          ALIGN_LOG2 = 2,
  parameter int unsigned OR_VAL     = 0
) (
  input  logic [REG_W-1:0]  reg_i,
  output logic [ADDR_W-1:0] base_o
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK =
    ~((ADDR_W'(1) << ALIGN_LOG2) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] OR_BITS = ADDR_W'(OR_VAL);

  logic [ADDR_W-1:0] shifted;

  assign shifted = ADDR_W'({reg_i, 2'b00});
  assign base_o  = (shifted & ALIGN_MASK) | OR_BITS;

endmodule

// File: rtl/route_par_ctl.sv
module route_par_ctl
  import route_pkg::*;
#(
  parameter int          REG_W   = 8,
  parameter int          ADDR_W  = 16,
  parameter int unsigned WIN_LO  = 32'h100,
  parameter int unsigned WIN_HI  = 32'hFFC
) (
  input  logic [1:0]        mode_i,
  input  logic              opt_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              ext_o,
  output logic              ecp_o,
  output logic              epp_o
);

  localparam logic [ADDR_W-1:0] LO     = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI_W4  = ADDR_W'(WIN_HI) & ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] HI_W8  = ADDR_W'(WIN_HI) & ~ADDR_W'(7);

  logic [ADDR_W-1:0] base_a4;
  logic [ADDR_W-1:0] base_a8;
  logic [ADDR_W-1:0] hi_lim;
  par_mode_e         mode;

  route_base_calc #(.REG_W(REG_W), .ADDR_W(ADDR_W), .ALIGN_LOG2(2), .OR_VAL(0))
    u_align4 (.reg_i(reg_i), .base_o(base_a4));

  route_base_calc #(.REG_W(REG_W), .ADDR_W(ADDR_W), .ALIGN_LOG2(3), .OR_VAL(0))
    u_align8 (.reg_i(reg_i), .base_o(base_a8));

  assign mode = par_mode_e'(mode_i);

  always_comb begin
    ext_o  = 1'b0;
    ecp_o  = 1'b0;
    epp_o  = 1'b0;
    base_o = base_a4;
    hi_lim = HI_W4;
    case (mode)
      PAR_STD: ext_o = 1'b1;
      PAR_ECP: begin
        ecp_o = 1'b1;
        epp_o = opt_i;
      end
      PAR_EPP: begin
        epp_o  = 1'b1;
        ecp_o  = opt_i;
        base_o = base_a8;
        hi_lim = HI_W8;
      end
      default: ;
    endcase
  end

  assign en_o = (mode != PAR_OFF) && (base_o >= LO) && (base_o <= hi_lim);

endmodule

// File: rtl/periph_route_dec.sv
module periph_route_dec
  import route_pkg::*;
#(
  parameter int          REG_W   = 8,
  parameter int          ADDR_W  = 16,
  parameter int unsigned PAR_LO  = 32'h100,
  parameter int unsigned PAR_HI  = 32'hFFC
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_upd,
  input  logic [7:0]                  cfg_enables,
  input  logic [REG_W-1:0]            cfg_fdc_base,
  input  logic [REG_W-1:0]            cfg_ide_pri,
  input  logic [REG_W-1:0]            cfg_ide_sec,
  input  logic [REG_W-1:0]            cfg_par_base,
  input  logic [REG_W-1:0]            cfg_ser0_base,
  input  logic [REG_W-1:0]            cfg_ser1_base,
  input  logic [7:0]                  cfg_dma_sel,
  input  logic [7:0]                  cfg_irq_fp,
  input  logic [7:0]                  cfg_irq_ser,
  input  logic [7:0]                  cfg_clk_fast,
  input  logic [7:0]                  cfg_clk_mid,
  input  logic [7:0]                  cfg_par_opt,
  input  logic [7:0]                  cfg_par_fifo,
  output logic                        fdc_en,
  output logic [ADDR_W-1:0]           fdc_base,
  output logic [IRQ_W-1:0]            fdc_irq,
  output logic                        fdc_irq_vld,
  output logic [DMA_W-1:0]            fdc_dma,
  output logic                        ide_en,
  output logic [ADDR_W-1:0]           ide_pri_base,
  output logic [ADDR_W-1:0]           ide_sec_base,
  output logic [NUM_SER-1:0]          ser_en,
  output logic [NUM_SER*ADDR_W-1:0]   ser_base,
  output logic [NUM_SER*IRQ_W-1:0]    ser_irq,
  output logic [NUM_SER-1:0]          ser_irq_vld,
  output logic [NUM_SER*2-1:0]        ser_baud_sel,
  output logic                        par_en,
  output logic [ADDR_W-1:0]           par_base,
  output logic [IRQ_W-1:0]            par_irq,
  output logic                        par_irq_vld,
  output logic [DMA_W-1:0]            par_dma,
  output logic                        par_ext,
  output logic                        par_ecp,
  output logic                        par_epp,
  output logic [3:0]                  par_fifo_thr
);

  // Bit positions inside the enable byte.
  localparam int EN_IDE_BIT = 5;
  localparam int EN_FDC_BIT = 4;
  localparam int EN_SER_BIT = 2;
  localparam int OPT_BIT    = 5;
  localparam int FAST_BIT   = 6;

  // ---------------- combinational decode ----------------
  logic [ADDR_W-1:0]         fdc_base_d, ide_pri_d, ide_sec_d, par_base_d;
  irq_res_t                  fdc_irq_d, par_irq_d;
  irq_res_t [NUM_SER-1:0]    ser_irq_d;
  logic [NUM_SER*ADDR_W-1:0] ser_base_d;
  logic [NUM_SER*2-1:0]      ser_baud_d;
  logic                      par_en_d, par_ext_d, par_ecp_d, par_epp_d;

  route_base_calc #(.REG_W(REG_W), .ADDR_W(ADDR_W), .ALIGN_LOG2(4), .OR_VAL(0))
    u_fdc_base (.reg_i(cfg_fdc_base), .base_o(fdc_base_d));

  route_base_calc #(.REG_W(REG_W), .ADDR_W(ADDR_W), .ALIGN_LOG2(4), .OR_VAL(0))
    u_ide_pri (.reg_i(cfg_ide_pri), .base_o(ide_pri_d));

  route_base_calc #(.REG_W(REG_W), .ADDR_W(ADDR_W), .ALIGN_LOG2(4), .OR_VAL(6))
    u_ide_sec (.reg_i(cfg_ide_sec), .base_o(ide_sec_d));

  route_irq_lut #(.CODE_W(4)) u_fdc_irq (.code_i(cfg_irq_fp[7:4]), .res_o(fdc_irq_d));
  route_irq_lut #(.CODE_W(4)) u_par_irq (.code_i(cfg_irq_fp[3:0]), .res_o(par_irq_d));

  for (genvar n = 0; n < NUM_SER; n++) begin : g_ser
    logic [REG_W-1:0] byte_sel;
    baud_sel_e        baud;

    assign byte_sel = (n == 0) ? cfg_ser0_base : cfg_ser1_base;

    route_base_calc #(.REG_W(REG_W), .ADDR_W(ADDR_W), .ALIGN_LOG2(3), .OR_VAL(0))
      u_base (.reg_i(byte_sel), .base_o(ser_base_d[n*ADDR_W +: ADDR_W]));

    // Serial 0 uses the high nibble, serial 1 the low nibble.
    route_irq_lut #(.CODE_W(4))
      u_irq (.code_i(cfg_irq_ser[4*(NUM_SER-1-n) +: 4]), .res_o(ser_irq_d[n]));

    always_comb begin
      if (cfg_clk_fast[FAST_BIT+n])  baud = BAUD_DIV3;
      else if (cfg_clk_mid[n])       baud = BAUD_DIV12;
      else                           baud = BAUD_DIV13;
    end
    assign ser_baud_d[2*n +: 2] = baud;
  end

  route_par_ctl #(.REG_W(REG_W), .ADDR_W(ADDR_W), .WIN_LO(PAR_LO), .WIN_HI(PAR_HI))
    u_par (
      .mode_i (cfg_enables[1:0]),
      .opt_i  (cfg_par_opt[OPT_BIT]),
      .reg_i  (cfg_par_base),
      .en_o   (par_en_d),
      .base_o (par_base_d),
      .ext_o  (par_ext_d),
      .ecp_o  (par_ecp_d),
      .epp_o  (par_epp_d)
    );

  logic unused_cfg;
  assign unused_cfg = ^{cfg_enables[7:6], cfg_dma_sel[7:6], cfg_dma_sel[3:2],
                        cfg_clk_fast[5:0], cfg_clk_mid[7:2], cfg_par_opt[7:6],
                        cfg_par_opt[4:0], cfg_par_fifo[7:4]};

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      fdc_en       <= 1'b0;
      fdc_base     <= '0;
      fdc_irq      <= IRQ_NONE;
      fdc_irq_vld  <= 1'b0;
      fdc_dma      <= DMA_NONE;
      ide_en       <= 1'b0;
      ide_pri_base <= '0;
      ide_sec_base <= '0;
      ser_en       <= '0;
      ser_base     <= '0;
      ser_irq      <= {NUM_SER{IRQ_NONE}};
      ser_irq_vld  <= '0;
      ser_baud_sel <= '0;
      par_en       <= 1'b0;
      par_base     <= '0;
      par_irq      <= IRQ_NONE;
      par_irq_vld  <= 1'b0;
      par_dma      <= DMA_NONE;
      par_ext      <= 1'b0;
      par_ecp      <= 1'b0;
      par_epp      <= 1'b0;
      par_fifo_thr <= '0;
    end else if (cfg_upd) begin
      fdc_en       <= cfg_enables[EN_FDC_BIT];
      fdc_base     <= fdc_base_d;
      fdc_irq      <= fdc_irq_d.num;
      fdc_irq_vld  <= fdc_irq_d.vld;
      fdc_dma      <= dma_decode(cfg_dma_sel[5:4]);
      ide_en       <= cfg_enables[EN_IDE_BIT];
      ide_pri_base <= ide_pri_d;
      ide_sec_base <= ide_sec_d;
      ser_en       <= cfg_enables[EN_SER_BIT +: NUM_SER];
      ser_base     <= ser_base_d;
      for (int i = 0; i < NUM_SER; i++) begin
        ser_irq[i*IRQ_W +: IRQ_W] <= ser_irq_d[i].num;
        ser_irq_vld[i]            <= ser_irq_d[i].vld;
      end
      ser_baud_sel <= ser_baud_d;
      par_en       <= par_en_d;
      par_base     <= par_base_d;
      par_irq      <= par_irq_d.num;
      par_irq_vld  <= par_irq_d.vld;
      par_dma      <= dma_decode(cfg_dma_sel[1:0]);
      par_ext      <= par_ext_d;
      par_ecp      <= par_ecp_d;
      par_epp      <= par_epp_d;
      par_fifo_thr <= cfg_par_fifo[3:0];
    end
  end

  // ---------------- assertions ----------------
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_upd |=> $stable({fdc_en, fdc_base, fdc_irq, fdc_dma, ide_en, ide_pri_base,
                          ide_sec_base, ser_en, ser_base, ser_irq, ser_baud_sel,
                          par_en, par_base, par_irq, par_dma, par_ext, par_ecp,
                          par_epp, par_fifo_thr})); // R1

  AST_FDC_EN_TRACK: assert property (@(posedge clk) disable iff (rst)
    cfg_upd |=> (fdc_en == $past(cfg_enables[EN_FDC_BIT]))); // R3

  AST_IRQ_NONE_CODE: assert property (@(posedge clk) disable iff (rst)
    !fdc_irq_vld |-> (fdc_irq == IRQ_NONE)); // R6

  AST_DMA_RANGE: assert property (@(posedge clk) disable iff (rst)
    (fdc_dma != 3'd0) && (fdc_dma <= DMA_NONE) && (par_dma != 3'd0)); // R7

  AST_PAR_EXT_ALONE: assert property (@(posedge clk) disable iff (rst)
    par_ext |-> (!par_ecp && !par_epp)); // R9

  AST_PAR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    par_en |-> ((par_base >= ADDR_W'(PAR_LO)) && (par_base <= ADDR_W'(PAR_HI)))); // R10

endmodule

// File: tb/periph_route_dec_tb_top.sv
`timescale 1ns/1ps
module periph_route_dec_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd = 1'b0;
  logic [7:0] en, fdcb, ipri, isec, parb, s0b, s1b, dma, irqfp, irqs, cfast, cmid, popt, pfifo;

  logic        fdc_en, fdc_irq_vld, ide_en, par_en, par_irq_vld, par_ext, par_ecp, par_epp;
  logic [15:0] fdc_base, ide_pri_base, ide_sec_base, par_base;
  logic [3:0]  fdc_irq, par_irq, ser_baud_sel, par_fifo_thr;
  logic [2:0]  fdc_dma, par_dma;
  logic [1:0]  ser_en, ser_irq_vld;
  logic [31:0] ser_base;
  logic [7:0]  ser_irq;

  // Snapshot last loaded by a strobe.
  logic [7:0] s_en, s_fdcb, s_ipri, s_isec, s_parb, s_s0b, s_s1b, s_dma, s_irqfp, s_irqs,
              s_cfast, s_cmid, s_popt, s_pfifo;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  periph_route_dec dut_i (
    .clk(clk), .rst(rst), .cfg_upd(upd),
    .cfg_enables(en), .cfg_fdc_base(fdcb), .cfg_ide_pri(ipri), .cfg_ide_sec(isec),
    .cfg_par_base(parb), .cfg_ser0_base(s0b), .cfg_ser1_base(s1b), .cfg_dma_sel(dma),
    .cfg_irq_fp(irqfp), .cfg_irq_ser(irqs), .cfg_clk_fast(cfast), .cfg_clk_mid(cmid),
    .cfg_par_opt(popt), .cfg_par_fifo(pfifo),
    .fdc_en(fdc_en), .fdc_base(fdc_base), .fdc_irq(fdc_irq), .fdc_irq_vld(fdc_irq_vld),
    .fdc_dma(fdc_dma), .ide_en(ide_en), .ide_pri_base(ide_pri_base),
    .ide_sec_base(ide_sec_base), .ser_en(ser_en), .ser_base(ser_base), .ser_irq(ser_irq),
    .ser_irq_vld(ser_irq_vld), .ser_baud_sel(ser_baud_sel), .par_en(par_en),
    .par_base(par_base), .par_irq(par_irq), .par_irq_vld(par_irq_vld), .par_dma(par_dma),
    .par_ext(par_ext), .par_ecp(par_ecp), .par_epp(par_epp), .par_fifo_thr(par_fifo_thr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] m_irq(input logic [3:0] c);
    case (c)
      4'd1: return {1'b1, 4'd5};
      4'd2: return {1'b1, 4'd2};
      4'd3: return {1'b1, 4'd3};
      4'd4: return {1'b1, 4'd4};
      4'd5: return {1'b1, 4'd7};
      4'd6: return {1'b1, 4'd6};
      4'd8: return {1'b1, 4'd10};
      default: return {1'b0, 4'hF};
    endcase
  endfunction

  function automatic logic [2:0] m_dma(input logic [1:0] c);
    return (c == 2'd0) ? 3'd4 : {1'b0, c};
  endfunction

  function automatic logic [1:0] m_baud(input int n);
    if (s_cfast[6+n]) return 2'd2;
    if (s_cmid[n])    return 2'd1;
    return 2'd0;
  endfunction

  task automatic check_all(input string tag);
    logic [15:0] mask, pb, hi;
    logic [1:0]  mode;
    logic        o;
    chk("R3", {tag, " fdc_en"}, fdc_en, s_en[4]);
    chk("R3", {tag, " ide_en"}, ide_en, s_en[5]);
    chk("R3", {tag, " ser_en"}, ser_en, s_en[3:2]);
    chk("R4", {tag, " fdc_base"}, fdc_base, {6'd0, s_fdcb, 2'b00} & 16'hFFF0);
    chk("R4", {tag, " ide_pri"}, ide_pri_base, {6'd0, s_ipri, 2'b00} & 16'hFFF0);
    chk("R4", {tag, " ide_sec"}, ide_sec_base, ({6'd0, s_isec, 2'b00} & 16'hFFF0) | 16'h6);
    chk("R5", {tag, " ser_base"}, ser_base,
        {{6'd0, s_s1b, 2'b00} & 16'hFFF8, {6'd0, s_s0b, 2'b00} & 16'hFFF8});
    chk("R6", {tag, " fdc_irq"}, {fdc_irq_vld, fdc_irq}, m_irq(s_irqfp[7:4]));
    chk("R6", {tag, " par_irq"}, {par_irq_vld, par_irq}, m_irq(s_irqfp[3:0]));
    chk("R6", {tag, " ser0_irq"}, {ser_irq_vld[0], ser_irq[3:0]}, m_irq(s_irqs[7:4]));
    chk("R6", {tag, " ser1_irq"}, {ser_irq_vld[1], ser_irq[7:4]}, m_irq(s_irqs[3:0]));
    chk("R7", {tag, " fdc_dma"}, fdc_dma, m_dma(s_dma[5:4]));
    chk("R7", {tag, " par_dma"}, par_dma, m_dma(s_dma[1:0]));
    chk("R8", {tag, " baud"}, ser_baud_sel, {m_baud(1), m_baud(0)});
    mode = s_en[1:0];
    o    = s_popt[5];
    chk("R9", {tag, " par_flags"}, {par_ext, par_ecp, par_epp},
        (mode == 2'd0) ? 3'b100 : (mode == 2'd1) ? {2'b01, o} :
        (mode == 2'd2) ? {1'b0, o, 1'b1} : 3'b000);
    mask = (mode == 2'd2) ? 16'hFFF8 : 16'hFFFC;
    pb   = {6'd0, s_parb, 2'b00} & mask;
    hi   = 16'hFFC & mask;
    chk("R10", {tag, " par_base"}, par_base, pb);
    chk("R10", {tag, " par_en"}, par_en, (mode != 2'd3) && (pb >= 16'h100) && (pb <= hi));
    chk("R11", {tag, " fifo"}, par_fifo_thr, s_pfifo[3:0]);
  endtask

  task automatic randomize_inputs();
    en = 8'($urandom); fdcb = 8'($urandom); ipri = 8'($urandom); isec = 8'($urandom);
    parb = 8'($urandom); s0b = 8'($urandom); s1b = 8'($urandom); dma = 8'($urandom);
    irqfp = 8'($urandom); irqs = 8'($urandom); cfast = 8'($urandom); cmid = 8'($urandom);
    popt = 8'($urandom); pfifo = 8'($urandom);
  endtask

  // Pulse the strobe for one edge, then sample on the following falling edge.
  task automatic load_and_check(input string tag);
    upd = 1'b1;
    @(posedge clk);
    s_en = en; s_fdcb = fdcb; s_ipri = ipri; s_isec = isec; s_parb = parb; s_s0b = s0b;
    s_s1b = s1b; s_dma = dma; s_irqfp = irqfp; s_irqs = irqs; s_cfast = cfast;
    s_cmid = cmid; s_popt = popt; s_pfifo = pfifo;
    @(negedge clk);
    upd = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    randomize_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2", "en", {fdc_en, ide_en, ser_en, par_en, par_ext, par_ecp, par_epp}, 8'd0);
    chk("R2", "bases", {fdc_base, ide_pri_base, ide_sec_base, par_base}, 64'd0);
    chk("R2", "ser_base", ser_base, 32'd0);
    chk("R2", "irqs", {fdc_irq_vld, fdc_irq, par_irq_vld, par_irq}, {5'h0F, 5'h0F});
    chk("R2", "ser_irq", {ser_irq_vld, ser_irq}, {2'b00, 8'hFF});
    chk("R2", "dma", {fdc_dma, par_dma}, {3'd4, 3'd4});
    chk("R2", "misc", {ser_baud_sel, par_fifo_thr}, 8'd0);

    // Directed: every IRQ code on all four consumers (R6)
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      irqfp = {c[3:0], c[3:0]};
      irqs  = {c[3:0], c[3:0]};
      load_and_check("R6 sweep");
    end
    // Directed: DMA codes (R7)
    for (int c = 0; c < 4; c++) begin
      dma = {2'b00, c[1:0], 2'b00, c[1:0]};
      load_and_check("R7 sweep");
    end
    // Directed: parallel modes, option bit, window edges (R9, R10)
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        en = {6'b0, m[1:0]}; popt = o[0] ? 8'h20 : 8'hDF;
        parb = 8'h3F; load_and_check("R10 below");
        parb = 8'h40; load_and_check("R10 low edge");
        parb = 8'h41; load_and_check("R10 align");
        parb = 8'hFF; load_and_check("R9 top");
      end
    end
    // Directed: baud select priority (R8)
    for (int b = 0; b < 16; b++) begin
      cfast = {b[3:2], 6'h15}; cmid = {6'h2A, b[1:0]};
      load_and_check("R8 prio");
    end
    // Random loads, with scrambled inputs between strobes (R1)
    for (int i = 0; i < 400; i++) begin
      randomize_inputs();
      load_and_check("rand");
      if (i % 3 == 0) begin
        randomize_inputs();
        repeat (2) @(negedge clk);
        check_all("R1 hold");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule